// File: doc/BRIEF.md
# Start-Gated Stop Event Shutter

This block sits between the start and stop event streams of a multi-channel time-to-digital converter. It decides which stop events may enter the output data stream. An asynchronous shutter level first passes through a two-flop synchronizer. Each start event then samples the synchronized level. A start may come from the external strobe, from the internal strobe, or from both in the same cycle.

A high sample closes the window that this start opens. Every stop event on every channel is then dropped until the next start takes a fresh sample. A low sample lets the stop events of that window through, one cycle later and with their data intact. A start counter counts every start event, whether its window is blocked or open.

After reset no window is open. Stop events are therefore dropped until the first start arrives.

Top module: `start_gated_shutter`

## Requirements
- R1: The shutter level passes through two flops before use. A start strobe sees a shutter change only if the change was applied at least two clock edges before the edge that registers the start.
- R2: A start event is a cycle in which `extStart`, `intStart` or both are high. All three cases sample the shutter in the same way.
- R3: When a start samples a high shutter, every stop event in its window is discarded. For such an event `outValid` stays 0 and `outData` for that channel reads 0.
- R4: When a start samples a low shutter, a stop event on channel i appears one cycle later as `outValid[i]=1`. Its data appears in `outData` bits [i*DATA_W +: DATA_W]. Channels that did not fire read valid 0 and data 0.
- R5: The pass/discard decision holds until the next start. Changes of the shutter level inside a window have no effect on that window.
- R6: A stop event in the same cycle as a start belongs to the new window and uses the new sample.
- R7: Between reset and the first start, all stop events are discarded.
- R8: Each start cycle adds exactly one to `startCount`, whatever the shutter level, and the new value shows one cycle later. A cycle with both strobes high counts once. A cycle with no start leaves the count unchanged.
- R9: `startCount` is CNT_W bits wide (32 by default) and wraps from all ones to zero.
- R10: A synchronous active-high `rst` clears the count, the outputs, the synchronizer and the window state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| extStart | input | 1 | External start strobe, one cycle |
| intStart | input | 1 | Internal start strobe, one cycle |
| shutterIn | input | 1 | Asynchronous shutter level, active high |
| stopValid | input | NUM_CH | Per-channel stop event valid |
| stopData | input | NUM_CH*DATA_W | Per-channel stop event data |
| outValid | output | NUM_CH | Forwarded stop event valid |
| outData | output | NUM_CH*DATA_W | Forwarded stop event data, zero where not valid |
| startCount | output | CNT_W | Start counter |

## Verification
The bench sweeps all three start sources, both shutter levels and every stop pattern on a two-channel, six-bit-counter build. It places stops in the start cycle itself, and a design that applied the old decision there would forward or drop exactly those events wrongly. It also raises the shutter in the middle of an open window and only one cycle before a start. A design that gated stops live, or that skipped the synchronizer, would then cut the window short or use the new level too early. Stops before the first start, double strobes that must count once, and a wrap of the counter catch a window left open by reset, double counting and a saturating counter.

// File: rtl/shutter_pkg.sv
package shutter_pkg;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic countInc;
    logic passStops;
  } ctrl_t;
endpackage

// File: rtl/shutter_sync.sv
module shutter_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/shutter_ctrl.sv
module shutter_ctrl
  import shutter_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  extStart,
  input  logic  intStart,
  input  logic  shutSync,
  output ctrl_t ctrl
);
  logic windowOpen;
  logic blockReg;
  logic startNow;

  assign startNow = extStart | intStart;

  always_ff @(posedge clk) begin
    if (rst) begin
      windowOpen <= 1'b0;
      blockReg   <= 1'b0;
    end else if (startNow) begin
      windowOpen <= 1'b1;
      blockReg   <= shutSync;
    end
  end

  always_comb begin
    ctrl.countInc  = startNow;
    ctrl.passStops = startNow ? ~shutSync : (windowOpen & ~blockReg);
  end
endmodule

// File: rtl/shutter_dp.sv
module shutter_dp
  import shutter_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrl_t                    ctrl,
  input  logic [NUM_CH-1:0]        stopValid,
  input  logic [NUM_CH*DATA_W-1:0] stopData,
  output logic [NUM_CH-1:0]        outValid,
  output logic [NUM_CH*DATA_W-1:0] outData,
  output logic [CNT_W-1:0]         startCount
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)                startCount <= '0;
    else if (ctrl.countInc) startCount <= startCount + ONE;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic keep;
    assign keep = stopValid[ch] & ctrl.passStops;

    always_ff @(posedge clk) begin
      if (rst) begin
        outValid[ch]                 <= 1'b0;
        outData[ch*DATA_W +: DATA_W] <= '0;
      end else begin
        outValid[ch]                 <= keep;
        outData[ch*DATA_W +: DATA_W] <= keep ? stopData[ch*DATA_W +: DATA_W] : '0;
      end
    end
  end
endmodule

// File: rtl/start_gated_shutter.sv
module start_gated_shutter
  import shutter_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     extStart,
  input  logic                     intStart,
  input  logic                     shutterIn,
  input  logic [NUM_CH-1:0]        stopValid,
  input  logic [NUM_CH*DATA_W-1:0] stopData,
  output logic [NUM_CH-1:0]        outValid,
  output logic [NUM_CH*DATA_W-1:0] outData,
  output logic [CNT_W-1:0]         startCount
);
  logic  shutSync;
  ctrl_t ctrl;

  shutter_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .asyncIn(shutterIn), .syncOut(shutSync)
  );

  shutter_ctrl u_ctrl (
    .clk(clk), .rst(rst), .extStart(extStart), .intStart(intStart),
    .shutSync(shutSync), .ctrl(ctrl)
  );

  shutter_dp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .stopValid(stopValid),
    .stopData(stopData), .outValid(outValid), .outData(outData),
    .startCount(startCount)
  );
endmodule

// File: rtl/shutter_checker.sv
module shutter_checker #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              extStart,
  input logic              intStart,
  input logic              shutterIn,
  input logic              shutSync,
  input logic [NUM_CH-1:0] stopValid,
  input logic [NUM_CH-1:0] outValid,
  input logic [CNT_W-1:0]  startCount
);
  logic [1:0] liveEdges;
  logic       seenStart;
  logic       winBlocked;
  logic       anyStart;

  assign anyStart = extStart | intStart;

  always_ff @(posedge clk) begin
    if (rst) begin
      liveEdges  <= '0;
      seenStart  <= 1'b0;
      winBlocked <= 1'b0;
    end else begin
      if (liveEdges != 2'd2) liveEdges <= liveEdges + 2'd1;
      if (anyStart) begin
        seenStart  <= 1'b1;
        winBlocked <= shutSync;
      end
    end
  end

  assert_sync_delay_R1: assert property (@(posedge clk) disable iff (rst)
    (liveEdges == 2'd2) |-> (shutSync == $past(shutterIn, 2)));

  assert_no_pass_before_start_R7: assert property (@(posedge clk) disable iff (rst)
    (outValid != '0) |-> seenStart);

  assert_blocked_window_R3: assert property (@(posedge clk) disable iff (rst)
    (outValid != '0) |-> !winBlocked);

  assert_forward_origin_R4: assert property (@(posedge clk) disable iff (rst)
    (liveEdges != 2'd0) |-> ((outValid & ~$past(stopValid)) == '0));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    (liveEdges != 2'd0 && $past(anyStart)) |-> (startCount == $past(startCount) + CNT_W'(1)));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (liveEdges != 2'd0 && !$past(anyStart)) |-> $stable(startCount));
endmodule

bind start_gated_shutter shutter_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .extStart(extStart), .intStart(intStart),
  .shutterIn(shutterIn), .shutSync(shutSync), .stopValid(stopValid),
  .outValid(outValid), .startCount(startCount)
);

// File: tb/start_gated_shutter_tb.sv
module start_gated_shutter_tb;
  localparam int NUM_CH = 2;
  localparam int DATA_W = 4;
  localparam int CNT_W  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic extStart = 1'b0, intStart = 1'b0, shutterIn = 1'b0;
  logic [NUM_CH-1:0]        stopValid = '0;
  logic [NUM_CH*DATA_W-1:0] stopData = '0;
  logic [NUM_CH-1:0]        outValid;
  logic [NUM_CH*DATA_W-1:0] outData;
  logic [CNT_W-1:0]         startCount;

  int errors = 0, checks = 0;
  bit finished = 0;
  string tag = "R10";

  // bench model state
  logic sync1 = 0, sync2 = 0, mOpen = 0, mBlk = 0;
  logic [CNT_W-1:0] mCount = '0;
  logic [NUM_CH-1:0] expValid;
  logic [NUM_CH*DATA_W-1:0] expData;
  int seq = 0;

  always #10 clk = ~clk;

  start_gated_shutter #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .extStart(extStart), .intStart(intStart),
    .shutterIn(shutterIn), .stopValid(stopValid), .stopData(stopData),
    .outValid(outValid), .outData(outData), .startCount(startCount)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, check at following negedge
  task automatic step(input logic e, input logic i, input logic sh, input logic [NUM_CH-1:0] sv);
    logic pass;
    extStart = e; intStart = i; shutterIn = sh; stopValid = sv;
    seq++;
    for (int c = 0; c < NUM_CH; c++) stopData[c*DATA_W +: DATA_W] = DATA_W'(seq * 3 + c + 1);
    if (e | i) begin mOpen = 1; mBlk = sync2; mCount = mCount + 1'b1; end
    pass = (e | i) ? ~sync2 : (mOpen & ~mBlk);
    for (int c = 0; c < NUM_CH; c++) begin
      expValid[c] = sv[c] & pass;
      expData[c*DATA_W +: DATA_W] = expValid[c] ? stopData[c*DATA_W +: DATA_W] : '0;
    end
    sync2 = sync1; sync1 = sh;
    @(negedge clk);
    check(tag, 32'(outValid), 32'(expValid), "outValid");
    check(tag, 32'(outData), 32'(expData), "outData");
    check(tag, 32'(startCount), 32'(mCount), "startCount");
  endtask

  task automatic do_reset();
    rst = 1; extStart = 0; intStart = 0; stopValid = '0;
    repeat (2) @(negedge clk);
    rst = 0;
    sync1 = 0; sync2 = 0; mOpen = 0; mBlk = 0; mCount = '0;
    tag = "R10";
    check(tag, 32'(outValid), 32'd0, "reset outValid");
    check(tag, 32'(outData), 32'd0, "reset outData");
    check(tag, 32'(startCount), 32'd0, "reset startCount");
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R7: no window before first start, either shutter level
    tag = "R7";
    for (int p = 0; p < 8; p++) step(0, 0, p[2], p[1:0]);

    // R2 R3 R4 R6: every start source x shutter level x stop pattern
    for (int k = 1; k < 4; k++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 4; p++) begin
          tag = "R2";
          repeat (3) step(0, 0, s[0], 2'b00);
          tag = "R6";
          step(k[0], k[1], s[0], p[1:0]);
          tag = s ? "R3" : "R4";
          step(0, 0, s[0], p[1:0]);
          step(0, 0, s[0], 2'b11);
        end

    // R5: shutter changes inside a window do not change it
    tag = "R5";
    repeat (3) step(0, 0, 0, 2'b00);
    step(1, 0, 0, 2'b01);
    for (int n = 0; n < 5; n++) step(0, 0, 1, 2'(n));
    repeat (2) step(0, 0, 1, 2'b00);
    step(0, 1, 0, 2'b10);
    for (int n = 0; n < 5; n++) step(0, 0, 0, 2'(n));

    // R1: shutter raised one cycle before the start is not yet seen
    tag = "R1";
    repeat (3) step(0, 0, 0, 2'b00);
    step(0, 0, 1, 2'b00);
    step(1, 0, 1, 2'b11);
    step(0, 0, 1, 2'b11);
    step(0, 0, 1, 2'b00);
    step(1, 0, 1, 2'b11);
    step(0, 0, 1, 2'b01);

    // R8 R9: counting every start (both strobes count once) through a wrap
    tag = "R8";
    for (int n = 0; n < 40; n++) step(n[0], n[1] | n[0], n[2], 2'b01);
    tag = "R9";
    for (int n = 0; n < 80; n++) step(1, n[0], n[3], 2'b00);
    step(0, 0, 0, 2'b00);

    // R10: reset mid-run clears window, counter and sync
    step(1, 0, 0, 2'b00);
    do_reset();
    tag = "R7";
    step(0, 0, 0, 2'b11);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule